// File: doc/BRIEF.md
# Chunk Race Recorder with Bloom Signatures

This block sits beside one processor core. It splits the core's execution into chunks. A chunk is a stretch of retired instructions during which no remote coherence request touched a line the core used. While a chunk runs, the block records the cache lines the core reads in a read signature and the lines it writes in a write signature. Both are Bloom filters. Each snooped remote request is tested against them. A remote read is a conflict when it hits the write signature. A remote write or invalidation is a conflict when it hits either signature. A conflict closes the chunk, and so does a full instruction counter. The block then emits one log entry that holds the chunk length and a scalar timestamp, clears both signatures, and advances the timestamp.

Ordering between cores comes from a scalar clock kept by each core. The block shows its current clock on `ownStamp`, which the core attaches to every coherence reply it sends. When the core receives a reply that carries another core's clock, the local clock moves up to that value if it is larger. A replayer can later order chunks from all cores by their logged timestamps. Log entries leave on a valid/ready stream with a single holding register. When a chunk must end while the previous entry has not been taken, the block raises `stall` and the core has to hold that cycle.

Top module: `chunk_rec`

## Requirements
- R1: A local access inserts its line into the read signature (1024 bits) when `memIsWrite`=0, and into the write signature (256 bits) when it is 1. For a signature of 2^k bits, index A is the XOR of all line bits i folded onto bit i mod k. Index B is the same fold with line bit LINE_W-1-i taken in place of bit i. An insert sets both indexed bits. A query hits only when both bits are set.
- R2: A snooped read (`snoopIsWrite`=0) is a conflict only when it hits the write signature. A hit in the read signature alone does not end the chunk.
- R3: A snooped write or invalidation (`snoopIsWrite`=1) is a conflict when it hits the read signature, the write signature, or both.
- R4: A snoop that hits neither signature leaves the chunk running: no log entry appears and the length count keeps growing.
- R5: When a chunk ends, the entry appears on the cycle after the end. Its length is the number of `retire` pulses since the previous end. A retire in the ending cycle counts toward the next chunk. Both signatures are cleared, and a local access made in the ending cycle is recorded into the new chunk.
- R6: `ownStamp` is a register that starts at 0. On a `replyValid` cycle it takes the larger of itself and `replyStamp`. When a chunk ends, the entry's timestamp is that merged value and `ownStamp` becomes the merged value plus one.
- R7: The length counter is LEN_W bits wide. When it holds its maximum value, the chunk ends without any snoop and the entry's length is 2^LEN_W-1.
- R8: `logValid` and the entry fields stay stable while `logReady` is low. An entry is removed on a cycle with `logReady` high.
- R9: `stall` is high in a cycle in which a chunk must end while an entry is pending and `logReady` is low. In that cycle no chunk ends, and the local access and the retire are ignored. The reply merge still takes place.
- R10: After reset `logValid` and `stall` are 0, `ownStamp` is 0 and both signatures are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction retired this cycle |
| memValid | input | 1 | Local memory access this cycle |
| memIsWrite | input | 1 | Local access is a write |
| memLine | input | LINE_W | Line address of local access |
| snoopValid | input | 1 | Remote coherence request this cycle |
| snoopIsWrite | input | 1 | Remote request is a write or invalidation |
| snoopLine | input | LINE_W | Line address of remote request |
| replyValid | input | 1 | Coherence reply received carrying a timestamp |
| replyStamp | input | TS_W | Timestamp on the received reply |
| ownStamp | output | TS_W | Local clock to attach to outgoing replies |
| logValid | output | 1 | Log entry available |
| logReady | input | 1 | Consumer takes the log entry |
| logLen | output | LEN_W | Length of the closed chunk in instructions |
| logStamp | output | TS_W | Timestamp of the closed chunk |
| stall | output | 1 | Core must hold: chunk end blocked by pending entry |

## Verification
Two kinds of work can land in the same cycle: closing a chunk, which clears the signatures, and recording a local access into them. The bench provokes this by driving a conflicting snoop together with a local write to a line not seen before. A following snoop read of that line must still conflict, which shows that the insert went into the new chunk. A second pair is a chunk end together with a reply merge. Here the logged timestamp must equal the merged maximum, and `ownStamp` must equal that value plus one. Every such cycle is judged against a cycle-by-cycle reference model of signatures, counter and clock kept in the bench.

// File: rtl/chunk_rec_pkg.sv
package chunk_rec_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic endChunk;   // close the chunk at this edge
    logic accept;     // core not stalled: take local access and retire
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic rdHit;      // snoop line present in read signature
    logic wrHit;      // snoop line present in write signature
    logic full;       // length counter at its maximum
  } dpStatus_t;

endpackage

// File: rtl/chunk_rec_sig.sv
module chunk_rec_sig #(
  parameter int LINE_W = 26,
  parameter int BITS   = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              ins,
  input  logic [LINE_W-1:0] insLine,
  input  logic [LINE_W-1:0] qLine,
  output logic              hit
);
  localparam int IW = $clog2(BITS);

  // fold of line bits onto IW index bits
  function automatic logic [IW-1:0] foldFwd(input logic [LINE_W-1:0] a);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < LINE_W; i++) r[i % IW] = r[i % IW] ^ a[i];
    return r;
  endfunction

  // same fold over the reversed line
  function automatic logic [IW-1:0] foldRev(input logic [LINE_W-1:0] a);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < LINE_W; i++) r[i % IW] = r[i % IW] ^ a[LINE_W-1-i];
    return r;
  endfunction

  logic [BITS-1:0] bits, bitsNext;
  logic [IW-1:0]   insA, insB, qA, qB;

  assign insA = foldFwd(insLine);
  assign insB = foldRev(insLine);
  assign qA   = foldFwd(qLine);
  assign qB   = foldRev(qLine);

  always_comb begin
    bitsNext = clr ? '0 : bits;
    if (ins) begin
      bitsNext[insA] = 1'b1;
      bitsNext[insB] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) bits <= '0;
    else       bits <= bitsNext;
  end

  assign hit = bits[qA] & bits[qB];

endmodule

// File: rtl/chunk_rec_dp.sv
module chunk_rec_dp
  import chunk_rec_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int RD_BITS = 1024,
  parameter int WR_BITS = 256,
  parameter int LEN_W   = 16,
  parameter int TS_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic              retire,
  input  logic              memValid,
  input  logic              memIsWrite,
  input  logic [LINE_W-1:0] memLine,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic              replyValid,
  input  logic [TS_W-1:0]   replyStamp,
  output dpStatus_t         st,
  output logic [TS_W-1:0]   ownStamp,
  output logic [LEN_W-1:0]  logLen,
  output logic [TS_W-1:0]   logStamp
);
  logic [1:0]       sigHit;
  logic [LEN_W-1:0] chunkCnt;
  logic [TS_W-1:0]  stampReg, mergedStamp;
  logic             retInc;

  // index 0 is the read signature, index 1 the write signature
  for (genvar g = 0; g < 2; g++) begin : gSig
    localparam int   BITS  = (g == 0) ? RD_BITS : WR_BITS;
    localparam logic IS_WR = (g == 1);
    chunk_rec_sig #(.LINE_W(LINE_W), .BITS(BITS)) u_sig (
      .clk     (clk),
      .rstN    (rstN),
      .clr     (stb.endChunk),
      .ins     (stb.accept & memValid & (memIsWrite == IS_WR)),
      .insLine (memLine),
      .qLine   (snoopLine),
      .hit     (sigHit[g])
    );
  end

  assign retInc      = retire & stb.accept;
  assign mergedStamp = (replyValid && (replyStamp > stampReg)) ? replyStamp : stampReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chunkCnt <= '0;
      stampReg <= '0;
      logLen   <= '0;
      logStamp <= '0;
    end else begin
      if (stb.endChunk) begin
        chunkCnt <= LEN_W'(retInc);
        stampReg <= mergedStamp + TS_W'(1);
        logLen   <= chunkCnt;
        logStamp <= mergedStamp;
      end else begin
        chunkCnt <= chunkCnt + LEN_W'(retInc);
        stampReg <= mergedStamp;
      end
    end
  end

  always_comb begin
    st.rdHit = sigHit[0];
    st.wrHit = sigHit[1];
    st.full  = &chunkCnt;
  end

  assign ownStamp = stampReg;

endmodule

// File: rtl/chunk_rec_ctrl.sv
module chunk_rec_ctrl
  import chunk_rec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        snoopValid,
  input  logic        snoopIsWrite,
  input  dpStatus_t   st,
  input  logic        logReady,
  output ctrlStrobe_t stb,
  output logic        logValid,
  output logic        stall
);
  logic conflict, endReq, pending;

  // reads clash with local writes; writes clash with anything local
  assign conflict = snoopValid & (st.wrHit | (snoopIsWrite & st.rdHit));
  assign endReq   = conflict | st.full;
  assign pending  = logValid & ~logReady;
  assign stall    = endReq & pending;

  always_comb begin
    stb.endChunk = endReq & ~pending;
    stb.accept   = ~stall;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             logValid <= 1'b0;
    else if (stb.endChunk) logValid <= 1'b1;
    else if (logReady)     logValid <= 1'b0;
  end

endmodule

// File: rtl/chunk_rec.sv
module chunk_rec
  import chunk_rec_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int RD_BITS = 1024,
  parameter int WR_BITS = 256,
  parameter int LEN_W   = 16,
  parameter int TS_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retire,
  input  logic              memValid,
  input  logic              memIsWrite,
  input  logic [LINE_W-1:0] memLine,
  input  logic              snoopValid,
  input  logic              snoopIsWrite,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic              replyValid,
  input  logic [TS_W-1:0]   replyStamp,
  output logic [TS_W-1:0]   ownStamp,
  output logic              logValid,
  input  logic              logReady,
  output logic [LEN_W-1:0]  logLen,
  output logic [TS_W-1:0]   logStamp,
  output logic              stall
);
  ctrlStrobe_t stb;
  dpStatus_t   st;

  chunk_rec_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .snoopValid   (snoopValid),
    .snoopIsWrite (snoopIsWrite),
    .st           (st),
    .logReady     (logReady),
    .stb          (stb),
    .logValid     (logValid),
    .stall        (stall)
  );

  chunk_rec_dp #(
    .LINE_W (LINE_W), .RD_BITS(RD_BITS), .WR_BITS(WR_BITS),
    .LEN_W  (LEN_W),  .TS_W   (TS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .retire     (retire),
    .memValid   (memValid),
    .memIsWrite (memIsWrite),
    .memLine    (memLine),
    .snoopLine  (snoopLine),
    .replyValid (replyValid),
    .replyStamp (replyStamp),
    .st         (st),
    .ownStamp   (ownStamp),
    .logLen     (logLen),
    .logStamp   (logStamp)
  );

endmodule

// File: rtl/chunk_rec_chk.sv
module chunk_rec_chk #(
  parameter int LEN_W = 16,
  parameter int TS_W  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             replyValid,
  input logic [TS_W-1:0]  replyStamp,
  input logic [TS_W-1:0]  ownStamp,
  input logic             logValid,
  input logic             logReady,
  input logic [LEN_W-1:0] logLen,
  input logic [TS_W-1:0]  logStamp,
  input logic             stall
);
  // R9: stall only while an untaken entry is waiting
  a_r9_stall_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (logValid && !logReady));

  // R8: untaken entry holds its contents
  a_r8_entry_holds: assert property (@(posedge clk) disable iff (!rstN)
    (logValid && !logReady) |=> (logValid && $stable(logLen) && $stable(logStamp)));

  // R6: local clock never moves backwards
  a_r6_clock_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (ownStamp >= $past(ownStamp)));

  // R6: a received stamp pulls the clock up to at least its value
  a_r6_reply_merge: assert property (@(posedge clk) disable iff (!rstN)
    replyValid |=> (ownStamp >= $past(replyStamp)));

  // R6: fresh entry is stamped one below the advanced clock
  a_r6_end_advance: assert property (@(posedge clk) disable iff (!rstN)
    $rose(logValid) |-> (ownStamp == TS_W'(logStamp + TS_W'(1))));

endmodule

bind chunk_rec chunk_rec_chk #(.LEN_W(LEN_W), .TS_W(TS_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .replyValid (replyValid),
  .replyStamp (replyStamp),
  .ownStamp   (ownStamp),
  .logValid   (logValid),
  .logReady   (logReady),
  .logLen     (logLen),
  .logStamp   (logStamp),
  .stall      (stall)
);

// File: tb/chunk_rec_bench.sv
module chunk_rec_bench;
  localparam int AW = 26;
  localparam int RB = 1024;
  localparam int WB = 256;
  localparam int LW = 8;
  localparam int TW = 32;
  localparam int CNT_MAX = (1 << LW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          retire, memValid, memIsWrite, snoopValid, snoopIsWrite;
  logic          replyValid, logReady;
  logic [AW-1:0] memLine, snoopLine;
  logic [TW-1:0] replyStamp;
  logic [TW-1:0] ownStamp, logStamp;
  logic [LW-1:0] logLen;
  logic          logValid, stall;

  always #10 clk = ~clk;

  chunk_rec #(.LINE_W(AW), .RD_BITS(RB), .WR_BITS(WB), .LEN_W(LW), .TS_W(TW)) u_chunk_rec (
    .clk(clk), .rstN(rstN), .retire(retire), .memValid(memValid), .memIsWrite(memIsWrite),
    .memLine(memLine), .snoopValid(snoopValid), .snoopIsWrite(snoopIsWrite),
    .snoopLine(snoopLine), .replyValid(replyValid), .replyStamp(replyStamp),
    .ownStamp(ownStamp), .logValid(logValid), .logReady(logReady), .logLen(logLen),
    .logStamp(logStamp), .stall(stall)
  );

  int nTests = 0;
  int nFail  = 0;
  logic [31:0] seed = 32'h1234_5678;

  // reference model state
  bit [RB-1:0]   mRd;
  bit [WB-1:0]   mWr;
  int            mCnt;
  logic [TW-1:0] mStamp;
  bit            mLogV;
  int            mLen;
  logic [TW-1:0] mLogSt;

  function automatic int idxA(logic [AW-1:0] a, int iw);
    int r = 0;
    for (int i = 0; i < AW; i++) if (a[i]) r = r ^ (1 << (i % iw));
    return r;
  endfunction

  function automatic int idxB(logic [AW-1:0] a, int iw);
    int r = 0;
    for (int i = 0; i < AW; i++) if (a[AW-1-i]) r = r ^ (1 << (i % iw));
    return r;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    retire = 1'b0; memValid = 1'b0; memIsWrite = 1'b0; memLine = '0;
    snoopValid = 1'b0; snoopIsWrite = 1'b0; snoopLine = '0;
    replyValid = 1'b0; replyStamp = '0; logReady = 1'b1;
  endtask

  // one clock: predict from the requirements, advance, compare
  task automatic tick(string tag);
    bit rdH, wrH, conf, endR, stE, doE;
    logic [TW-1:0] mg;
    #2;
    rdH  = mRd[idxA(snoopLine, 10)] && mRd[idxB(snoopLine, 10)];
    wrH  = mWr[idxA(snoopLine, 8)]  && mWr[idxB(snoopLine, 8)];
    conf = snoopValid && (wrH || (snoopIsWrite && rdH));
    endR = conf || (mCnt == CNT_MAX);
    stE  = endR && mLogV && !logReady;
    doE  = endR && !stE;
    chk(tag, "stall", 64'(stall), 64'(stE));
    mg = (replyValid && (replyStamp > mStamp)) ? replyStamp : mStamp;
    if (doE) begin mLogV = 1; mLen = mCnt; mLogSt = mg; end
    else if (logReady) mLogV = 0;
    if (doE) begin mRd = '0; mWr = '0; end
    if (!stE && memValid) begin
      if (memIsWrite) begin mWr[idxA(memLine, 8)] = 1; mWr[idxB(memLine, 8)] = 1; end
      else begin mRd[idxA(memLine, 10)] = 1; mRd[idxB(memLine, 10)] = 1; end
    end
    if (doE) mCnt = (retire && !stE) ? 1 : 0;
    else     mCnt = mCnt + ((retire && !stE) ? 1 : 0);
    mStamp = doE ? mg + 1 : mg;
    @(posedge clk); #1;
    chk(tag, "logValid", 64'(logValid), 64'(mLogV));
    chk(tag, "ownStamp", 64'(ownStamp), 64'(mStamp));
    if (mLogV) begin
      chk(tag, "logLen", 64'(logLen), 64'(mLen));
      chk(tag, "logStamp", 64'(logStamp), 64'(mLogSt));
    end
  endtask

  task automatic access(bit wr, logic [AW-1:0] ln, string tag);
    idle(); memValid = 1'b1; memIsWrite = wr; memLine = ln; retire = 1'b1; tick(tag);
  endtask

  task automatic snoop(bit wr, logic [AW-1:0] ln, string tag);
    idle(); snoopValid = 1'b1; snoopIsWrite = wr; snoopLine = ln; tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    idle();
    mRd = '0; mWr = '0; mCnt = 0; mStamp = '0; mLogV = 0; mLen = 0; mLogSt = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #2;
    // R10: state after reset
    chk("R10", "logValid", 64'(logValid), 64'(0));
    chk("R10", "stall", 64'(stall), 64'(0));
    chk("R10", "ownStamp", 64'(ownStamp), 64'(0));
    @(posedge clk); #1;
    snoop(1'b1, 26'h00abc, "R10");   // empty signatures: no conflict

    // R2: read-read is no conflict, read against local write is
    access(1'b0, 26'h0123, "R1");
    access(1'b0, 26'h0456, "R1");
    snoop(1'b0, 26'h0123, "R2");
    access(1'b1, 26'h0789, "R1");
    snoop(1'b0, 26'h0789, "R2");
    // R5: cleared after the end
    snoop(1'b1, 26'h0789, "R5");
    snoop(1'b1, 26'h0123, "R5");

    // R3: write snoop against local read and local write
    access(1'b0, 26'h1111, "R1");
    snoop(1'b1, 26'h1111, "R3");
    access(1'b1, 26'h2222, "R1");
    snoop(1'b1, 26'h2222, "R3");

    // R4: unrelated line keeps the chunk running
    access(1'b0, 26'h3333, "R1");
    snoop(1'b1, 26'h3334, "R4");
    snoop(1'b0, 26'h3001, "R4");
    access(1'b0, 26'h3335, "R4");

    // R5: end and insert in the same cycle; retire counts to the new chunk
    access(1'b1, 26'h4444, "R1");
    idle(); snoopValid = 1'b1; snoopIsWrite = 1'b0; snoopLine = 26'h4444;
    memValid = 1'b1; memIsWrite = 1'b1; memLine = 26'h5555; retire = 1'b1; tick("R5");
    snoop(1'b0, 26'h5555, "R5");

    // R6: clock merge and advance
    idle(); replyValid = 1'b1; replyStamp = 32'd100; tick("R6");
    idle(); replyValid = 1'b1; replyStamp = 32'd50;  tick("R6");
    access(1'b1, 26'h6666, "R6");
    idle(); snoopValid = 1'b1; snoopIsWrite = 1'b1; snoopLine = 26'h6666;
    replyValid = 1'b1; replyStamp = 32'd200; tick("R6");
    idle(); tick("R6");

    // R8 / R9: pending entry, then stall with ignored access and retire
    access(1'b1, 26'h7777, "R8");
    idle(); logReady = 1'b0; snoopValid = 1'b1; snoopLine = 26'h7777; tick("R8");
    idle(); logReady = 1'b0; memValid = 1'b1; memIsWrite = 1'b1; memLine = 26'h0a0a; tick("R8");
    for (int k = 0; k < 3; k++) begin
      idle(); logReady = 1'b0; snoopValid = 1'b1; snoopLine = 26'h0a0a;
      memValid = 1'b1; memIsWrite = 1'b1; memLine = 26'h0b0b; retire = 1'b1;
      replyValid = 1'b1; replyStamp = 32'd300 + 32'(k); tick("R9");
    end
    idle(); snoopValid = 1'b1; snoopLine = 26'h0a0a; tick("R9");
    snoop(1'b0, 26'h0b0b, "R9");     // stalled insert must be absent
    idle(); tick("R8");

    // R7: forced end when the counter is full
    idle(); retire = 1'b1;
    for (int k = 0; k < 2 * CNT_MAX + 10; k++) tick("R7");
    idle(); tick("R7");

    // near-exhaustive random sweep over small line pools
    for (int t = 0; t < 200; t++) begin
      int n;
      n = 1 + int'(rnd() % 6);
      for (int k = 0; k < n; k++) begin
        idle();
        memValid = rnd()[0]; memIsWrite = rnd()[1];
        memLine = AW'((rnd() % 24) * 37); retire = rnd()[2];
        logReady = (rnd() % 4) != 0;
        if (rnd()[3]) begin replyValid = 1'b1; replyStamp = mStamp + (rnd() % 5) - 2; end
        tick("R1");
      end
      for (int k = 0; k < 3; k++) begin
        idle();
        snoopValid = 1'b1; snoopIsWrite = rnd()[0];
        snoopLine = AW'((rnd() % 32) * 37);
        memValid = rnd()[1]; memIsWrite = rnd()[2]; memLine = AW'((rnd() % 24) * 37);
        logReady = (rnd() % 3) != 0;
        tick(snoopIsWrite ? "R3" : "R2");
      end
    end
    idle(); tick("R8"); tick("R8");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule